// File: doc/BRIEF.md
# Region Coherence Tracker

This block keeps coherence state for one processor at the granularity of regions. A region is an aligned, power-of-two group of cache lines. A small set-associative array holds, for each tracked region, a tag, a region state, a local-dirty flag and the number of lines from that region in the local cache. The block uses this state to avoid work. On a local miss it tells the request path whether a broadcast is needed or whether the request can go straight to memory. On an incoming snoop it returns a two-bit region response and says whether the snoop has to reach the cache tags at all.

All traffic arrives on one operation port, one operation per cycle. The operations are local read miss, local write miss, external read snoop, external ownership snoop, line fill, line eviction, and the combined region response for an earlier broadcast. Every operation gets a registered result on the following cycle.

Allocating a new region may displace an old one. If the old region still has lines in the local cache, the block issues a region-evict command so that the cache stays a subset of the tracked regions.

Top module: `region_tracker`

## Requirements
- R1: Reset invalidates every entry and clears all outputs. An operation accepted while `op_valid` is high produces `out_valid` high exactly one cycle later. Every result field is 0 unless the operation defines it.
- R2: The region number is `op_addr >> (log2(LINE_BYTES)+log2(LINES_PER_REGION))`, which is `op_addr[31:8]` with the defaults. Its low log2(SETS) bits select the set and the remaining bits form the tag. Addresses inside the same region hit the same entry.
- R3: A miss (code 0 = read, code 1 = write) to a region that is not tracked allocates an entry in the pending state with a line count of zero, and sets `out_bcast` to 1.
- R4: The response operation (code 6) on a tracked region sets its state from `op_resp`: 00 gives exclusive-local, bit 1 set gives externally-dirty, and only bit 0 set gives externally-clean. A response for an untracked region has no effect.
- R5: A miss that hits a tracked region sets `out_bcast` as follows. Exclusive-local gives 0. Externally-clean gives 0 for a read and 1 for a write. Externally-dirty and pending give 1.
- R6: A snoop (code 2 = read, code 3 = ownership) returns `out_snp_resp` = 00 when the region is untracked or its count is zero. Otherwise it returns 10 (dirty) if any write miss has hit or allocated the entry, and 01 (clean) if not. The value 11 never appears.
- R7: `out_to_tags` is 1 only for a snoop to a tracked region whose line count is nonzero.
- R8: A read snoop turns exclusive-local into externally-clean. An ownership snoop turns any non-pending valid state into externally-dirty.
- R9: A fill (code 4) increments the count and saturates at LINES_PER_REGION. A line eviction (code 5) decrements it and never goes below zero.
- R10: The victim is the lowest invalid way, else the lowest way with a zero count, else way 0. Displacing a region with a nonzero count raises `out_evict_valid` with that region's number on `out_evict_rgn`. Displacing a region with a zero count raises nothing.
- R11: A fill or eviction for an untracked region changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation code (0..6, 7 = no-op) |
| op_addr | input | ADDR_W | Byte address of the operation |
| op_resp | input | 2 | Combined region response for code 6 |
| out_valid | output | 1 | Result of the previous cycle's operation |
| out_bcast | output | 1 | Miss needs a broadcast |
| out_snp_resp | output | 2 | Region snoop response {dirty, clean} |
| out_to_tags | output | 1 | Snoop must be looked up in the cache tags |
| out_evict_valid | output | 1 | Evict all lines of `out_evict_rgn` |
| out_evict_rgn | output | ADDR_W-RGN_OFS | Region number to evict |

## Verification
The assertions check several properties on every cycle. The result follows its operation by one cycle. Broadcasts and evict commands come only from misses, and an evict command always comes with a broadcast. The snoop response is never 11, and a tag lookup is never requested with a 00 response.

Other properties depend on stored history, and only the bench's scenarios can show them. These are the state transitions from responses and snoops, count saturation and the floor at zero, victim choice among ways, and the dirty flag. The bench checks them against a reference model, with randomized operation sequences over a small pool of regions that forces set conflicts.

// File: rtl/rgn_trk_pkg.sv
package rgn_trk_pkg;
  typedef enum logic [2:0] {
    RS_INV  = 3'd0,
    RS_PEND = 3'd1,
    RS_EXCL = 3'd2,
    RS_EXTC = 3'd3,
    RS_EXTD = 3'd4
  } rgn_state_e;

  typedef enum logic [2:0] {
    OP_MISS_RD = 3'd0,
    OP_MISS_WR = 3'd1,
    OP_SNP_RD  = 3'd2,
    OP_SNP_OWN = 3'd3,
    OP_FILL    = 3'd4,
    OP_DROP    = 3'd5,
    OP_RESP    = 3'd6,
    OP_NOP     = 3'd7
  } rgn_op_e;

  // Final region state from a combined region response.
  function automatic rgn_state_e resp_to_state(input logic [1:0] r);
    if (r[1])      return RS_EXTD;
    else if (r[0]) return RS_EXTC;
    else           return RS_EXCL;
  endfunction
endpackage

// File: rtl/rgn_trk_match.sv
module rgn_trk_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 22,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]       vld,
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]      key,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way
);
  logic [WAYS-1:0] eq;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign eq[g] = vld[g] && (tags[g*TAG_W +: TAG_W] == key);
  end

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (eq[w] && !hit) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/rgn_trk_victim.sv
module rgn_trk_victim #(
  parameter int WAYS  = 2,
  parameter int CNT_W = 3,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]       vld,
  input  logic [WAYS*CNT_W-1:0] cnts,
  output logic [WAY_W-1:0]      way
);
  logic got_free, got_empty;
  logic [WAY_W-1:0] free_way, empty_way;

  always_comb begin
    got_free  = 1'b0;
    got_empty = 1'b0;
    free_way  = '0;
    empty_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vld[w] && !got_free) begin
        got_free = 1'b1;
        free_way = WAY_W'(w);
      end
      if (vld[w] && cnts[w*CNT_W +: CNT_W] == '0 && !got_empty) begin
        got_empty = 1'b1;
        empty_way = WAY_W'(w);
      end
    end
    if (got_free)       way = free_way;
    else if (got_empty) way = empty_way;
    else                way = '0;
  end
endmodule

// File: rtl/rgn_trk_cnt.sv
module rgn_trk_cnt #(
  parameter int CNT_W = 3,
  parameter int MAX   = 4
) (
  input  logic [CNT_W-1:0] cur,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] nxt
);
  always_comb begin
    nxt = cur;
    if (inc && cur != CNT_W'(MAX))  nxt = cur + 1'b1;
    else if (dec && cur != '0)      nxt = cur - 1'b1;
  end
endmodule

// File: rtl/region_tracker.sv
module region_tracker
  import rgn_trk_pkg::*;
#(
  parameter int ADDR_W           = 32,
  parameter int LINE_BYTES       = 64,
  parameter int LINES_PER_REGION = 4,
  parameter int SETS             = 4,
  parameter int WAYS             = 2,
  localparam int RGN_OFS = $clog2(LINE_BYTES) + $clog2(LINES_PER_REGION),
  localparam int RN_W    = ADDR_W - RGN_OFS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [1:0]        op_resp,
  output logic              out_valid,
  output logic              out_bcast,
  output logic [1:0]        out_snp_resp,
  output logic              out_to_tags,
  output logic              out_evict_valid,
  output logic [RN_W-1:0]   out_evict_rgn
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = RN_W - SET_W;
  localparam int CNT_W = $clog2(LINES_PER_REGION + 1);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  rgn_state_e       st_q    [SETS][WAYS];
  logic             dirty_q [SETS][WAYS];
  logic [CNT_W-1:0] cnt_q   [SETS][WAYS];

  rgn_op_e          op;
  logic [RN_W-1:0]  rn;
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] key;
  logic             unused_ofs;

  assign op         = rgn_op_e'(op_code);
  assign rn         = op_addr[ADDR_W-1:RGN_OFS];
  assign set_idx    = rn[SET_W-1:0];
  assign key        = rn[RN_W-1:SET_W];
  assign unused_ofs = ^op_addr[RGN_OFS-1:0];

  logic [WAYS-1:0]       vld_vec;
  logic [WAYS*TAG_W-1:0] tag_flat;
  logic [WAYS*CNT_W-1:0] cnt_flat;

  for (genvar g = 0; g < WAYS; g++) begin : g_set_view
    assign vld_vec[g]                 = (st_q[set_idx][g] != RS_INV);
    assign tag_flat[g*TAG_W +: TAG_W] = tag_q[set_idx][g];
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q[set_idx][g];
  end

  logic             hit;
  logic [WAY_W-1:0] hit_way, vic_way;

  rgn_trk_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .vld(vld_vec), .tags(tag_flat), .key(key), .hit(hit), .hit_way(hit_way));

  rgn_trk_victim #(.WAYS(WAYS), .CNT_W(CNT_W)) u_victim (
    .vld(vld_vec), .cnts(cnt_flat), .way(vic_way));

  rgn_state_e       hit_st;
  logic             hit_dirty;
  logic [CNT_W-1:0] hit_cnt, cnt_nx;

  assign hit_st    = st_q[set_idx][hit_way];
  assign hit_dirty = dirty_q[set_idx][hit_way];
  assign hit_cnt   = cnt_q[set_idx][hit_way];

  rgn_trk_cnt #(.CNT_W(CNT_W), .MAX(LINES_PER_REGION)) u_cnt (
    .cur(hit_cnt), .inc(op == OP_FILL), .dec(op == OP_DROP), .nxt(cnt_nx));

  logic            nx_bcast, nx_tags, nx_evict;
  logic [1:0]      nx_resp;
  logic [RN_W-1:0] nx_evict_rgn;
  rgn_state_e      snp_st;

  always_comb begin
    nx_bcast     = 1'b0;
    nx_tags      = 1'b0;
    nx_evict     = 1'b0;
    nx_resp      = 2'b00;
    nx_evict_rgn = '0;
    snp_st       = hit_st;
    case (op)
      OP_MISS_RD, OP_MISS_WR: begin
        if (hit) begin
          case (hit_st)
            RS_EXCL: nx_bcast = 1'b0;
            RS_EXTC: nx_bcast = (op == OP_MISS_WR);
            default: nx_bcast = 1'b1;
          endcase
        end else begin
          nx_bcast = 1'b1;
          if (vld_vec[vic_way] && cnt_q[set_idx][vic_way] != '0) begin
            nx_evict     = 1'b1;
            nx_evict_rgn = {tag_q[set_idx][vic_way], set_idx};
          end
        end
      end
      OP_SNP_RD, OP_SNP_OWN: begin
        if (hit && hit_cnt != '0) begin
          nx_tags = 1'b1;
          nx_resp = hit_dirty ? 2'b10 : 2'b01;
        end
        if (op == OP_SNP_OWN && hit_st != RS_PEND) snp_st = RS_EXTD;
        else if (op == OP_SNP_RD && hit_st == RS_EXCL) snp_st = RS_EXTC;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      out_bcast       <= 1'b0;
      out_snp_resp    <= 2'b00;
      out_to_tags     <= 1'b0;
      out_evict_valid <= 1'b0;
      out_evict_rgn   <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          st_q[s][w] <= RS_INV;
    end else begin
      out_valid       <= op_valid;
      out_bcast       <= op_valid & nx_bcast;
      out_snp_resp    <= op_valid ? nx_resp : 2'b00;
      out_to_tags     <= op_valid & nx_tags;
      out_evict_valid <= op_valid & nx_evict;
      out_evict_rgn   <= (op_valid & nx_evict) ? nx_evict_rgn : '0;
      if (op_valid) begin
        case (op)
          OP_MISS_RD, OP_MISS_WR: begin
            if (hit) begin
              if (op == OP_MISS_WR) dirty_q[set_idx][hit_way] <= 1'b1;
            end else begin
              tag_q[set_idx][vic_way]   <= key;
              st_q[set_idx][vic_way]    <= RS_PEND;
              dirty_q[set_idx][vic_way] <= (op == OP_MISS_WR);
              cnt_q[set_idx][vic_way]   <= '0;
            end
          end
          OP_SNP_RD, OP_SNP_OWN: if (hit) st_q[set_idx][hit_way] <= snp_st;
          OP_FILL, OP_DROP:      if (hit) cnt_q[set_idx][hit_way] <= cnt_nx;
          OP_RESP:               if (hit) st_q[set_idx][hit_way] <= resp_to_state(op_resp);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/region_tracker_chk.sv
module region_tracker_chk #(
  parameter int RN_W = 24
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input logic [2:0]      op_code,
  input logic            out_valid,
  input logic            out_bcast,
  input logic [1:0]      out_snp_resp,
  input logic            out_to_tags,
  input logic            out_evict_valid,
  input logic [RN_W-1:0] out_evict_rgn
);
  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(op_valid))); // R1

  AST_BCAST_FROM_MISS: assert property (@(posedge clk) disable iff (rst)
    out_bcast |-> ($past(op_valid) && $past(op_code) <= 3'd1)); // R5

  AST_EVICT_WITH_ALLOC: assert property (@(posedge clk) disable iff (rst)
    out_evict_valid |-> out_bcast); // R10

  AST_EVICT_RGN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_evict_valid |-> (out_evict_rgn == '0)); // R10

  AST_RESP_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_snp_resp)); // R6

  AST_RESP_FROM_SNOOP: assert property (@(posedge clk) disable iff (rst)
    (out_snp_resp != 2'b00) |-> ($past(op_valid) &&
      ($past(op_code) == 3'd2 || $past(op_code) == 3'd3))); // R6

  AST_TAGS_HAVE_RESP: assert property (@(posedge clk) disable iff (rst)
    out_to_tags |-> (out_snp_resp != 2'b00)); // R7
endmodule

bind region_tracker region_tracker_chk #(.RN_W(RN_W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .out_valid(out_valid), .out_bcast(out_bcast), .out_snp_resp(out_snp_resp),
  .out_to_tags(out_to_tags), .out_evict_valid(out_evict_valid),
  .out_evict_rgn(out_evict_rgn));

// File: tb/tb_region_tracker.sv
module tb_region_tracker;
  localparam int ADDR_W = 32;
  localparam int LINE_BYTES = 64;
  localparam int LPR = 4;
  localparam int SETS = 4;
  localparam int WAYS = 2;
  localparam int RGN_OFS = 8;
  localparam int RN_W = ADDR_W - RGN_OFS;

  // model state encoding
  localparam int M_INV = 0, M_PEND = 1, M_EXCL = 2, M_EXTC = 3, M_EXTD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [2:0] op_code = 3'd7;
  logic [ADDR_W-1:0] op_addr = '0;
  logic [1:0] op_resp = 2'b00;
  logic out_valid, out_bcast, out_to_tags, out_evict_valid;
  logic [1:0] out_snp_resp;
  logic [RN_W-1:0] out_evict_rgn;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  region_tracker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES),
    .LINES_PER_REGION(LPR), .SETS(SETS), .WAYS(WAYS)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_resp(op_resp), .out_valid(out_valid),
    .out_bcast(out_bcast), .out_snp_resp(out_snp_resp),
    .out_to_tags(out_to_tags), .out_evict_valid(out_evict_valid),
    .out_evict_rgn(out_evict_rgn));

  int          m_st    [SETS][WAYS];
  int unsigned m_tag   [SETS][WAYS];
  bit          m_dirty [SETS][WAYS];
  int          m_cnt   [SETS][WAYS];

  task automatic model(input int code, input logic [31:0] addr, input logic [1:0] rsp,
                       output logic [29:0] exp_vec);
    int unsigned rnum = addr >> RGN_OFS;
    int s = int'(rnum % SETS);
    int unsigned tg = rnum / SETS;
    int hw = -1;
    int vw;
    logic e_b = 0, e_t = 0, e_ev = 0;
    logic [1:0] e_r = 2'b00;
    logic [RN_W-1:0] e_rn = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (m_st[s][w] != M_INV && m_tag[s][w] == tg) hw = w;
    case (code)
      0, 1: begin
        if (hw >= 0) begin
          if (m_st[s][hw] == M_EXCL) e_b = 0;
          else if (m_st[s][hw] == M_EXTC) e_b = (code == 1);
          else e_b = 1;
          if (code == 1) m_dirty[s][hw] = 1;
        end else begin
          vw = -1;
          for (int w = WAYS - 1; w >= 0; w--) if (m_st[s][w] == M_INV) vw = w;
          if (vw < 0) for (int w = WAYS - 1; w >= 0; w--) if (m_cnt[s][w] == 0) vw = w;
          if (vw < 0) vw = 0;
          e_b = 1;
          if (m_st[s][vw] != M_INV && m_cnt[s][vw] != 0) begin
            e_ev = 1;
            e_rn = RN_W'(m_tag[s][vw] * SETS + s);
          end
          m_st[s][vw] = M_PEND; m_tag[s][vw] = tg;
          m_dirty[s][vw] = (code == 1); m_cnt[s][vw] = 0;
        end
      end
      2, 3: if (hw >= 0) begin
        if (m_cnt[s][hw] != 0) begin
          e_t = 1;
          e_r = m_dirty[s][hw] ? 2'b10 : 2'b01;
        end
        if (code == 3 && m_st[s][hw] != M_PEND) m_st[s][hw] = M_EXTD;
        else if (code == 2 && m_st[s][hw] == M_EXCL) m_st[s][hw] = M_EXTC;
      end
      4: if (hw >= 0 && m_cnt[s][hw] < LPR) m_cnt[s][hw]++;
      5: if (hw >= 0 && m_cnt[s][hw] > 0) m_cnt[s][hw]--;
      6: if (hw >= 0) m_st[s][hw] = rsp[1] ? M_EXTD : (rsp[0] ? M_EXTC : M_EXCL);
      default: ;
    endcase
    exp_vec = {1'b1, e_b, e_r, e_t, e_ev, e_rn};
  endtask

  function automatic string tag_for(input int code);
    case (code)
      0, 1: return "R5";
      2, 3: return "R6";
      4, 5: return "R9";
      6: return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic run_op(input int code, input logic [31:0] addr, input logic [1:0] rsp,
                        input string req);
    logic [29:0] exp_vec, act_vec;
    model(code, addr, rsp, exp_vec);
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'(code); op_addr = addr; op_resp = rsp;
    @(negedge clk);
    op_valid = 1'b0; op_code = 3'd7;
    act_vec = {out_valid, out_bcast, out_snp_resp, out_to_tags, out_evict_valid, out_evict_rgn};
    total++;
    if (act_vec !== exp_vec) begin
      bad++;
      $display("FAIL %s op=%0d addr=%h act=%h exp=%h", req, code, addr, act_vec, exp_vec);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [31:0] A = 32'h0000_1000; // region 0x10, set 0
  localparam logic [31:0] B = 32'h0000_1400; // region 0x14, set 0
  localparam logic [31:0] C = 32'h0000_1800; // region 0x18, set 0
  localparam logic [31:0] D = 32'h0000_1C00; // region 0x1c, set 0

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_st[s][w] = M_INV; m_tag[s][w] = 0; m_dirty[s][w] = 0; m_cnt[s][w] = 0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    total++;
    if ({out_valid, out_bcast, out_snp_resp, out_to_tags, out_evict_valid} !== 6'b0) begin
      bad++;
      $display("FAIL R1 reset outputs act=%b exp=000000",
               {out_valid, out_bcast, out_snp_resp, out_to_tags, out_evict_valid});
    end
    run_op(2, A, 0, "R6 untracked snoop after reset");
    run_op(0, A, 0, "R3 allocate pending");
    run_op(0, A + 32'h40, 0, "R5 pending still broadcasts (R2 same region)");
    run_op(6, A, 2'b00, "R4 response exclusive");
    run_op(0, A + 32'hC0, 0, "R5 exclusive read direct");
    run_op(1, A + 32'h80, 0, "R5 exclusive write direct");
    run_op(3, B, 0, "R7 untracked snoop");
    run_op(2, A, 0, "R7 zero count no tag lookup");
    for (int k = 0; k < 5; k++) run_op(4, A + 32'(k * 64), 0, "R9 fill saturates");
    run_op(2, A, 0, "R6 dirty response after write");
    run_op(1, A, 0, "R8 read snoop made it externally clean");
    run_op(0, A, 0, "R8 ext clean read direct");
    for (int k = 0; k < 4; k++) run_op(5, A, 0, "R9 drop");
    run_op(2, A, 0, "R9 saturated count reaches zero");
    run_op(5, A, 0, "R9 no underflow");
    run_op(4, A, 0, "R9 fill after floor");
    run_op(2, A, 0, "R9 count is one");
    run_op(3, A, 0, "R8 ownership snoop");
    run_op(0, A, 0, "R8 ext dirty read broadcasts");
    run_op(6, A, 2'b01, "R4 response clean");
    run_op(0, A, 0, "R4 ext clean read direct");
    run_op(4, B, 0, "R11 fill untracked");
    run_op(0, B, 0, "R10 invalid way first");
    run_op(2, B, 0, "R11 untracked fill ignored");
    run_op(0, C, 0, "R10 zero count victim no command");
    run_op(4, C, 0, "R9 fill C");
    run_op(0, D, 0, "R10 evict command for way 0");
    run_op(6, B, 2'b00, "R4 response untracked ignored");
    run_op(0, B, 0, "R4 untracked response left no entry");
    // constrained random over a pool of 12 regions in 4 sets
    void'($urandom(32'h1234_5eed));
    for (int i = 0; i < 600; i++) begin
      int code = int'($urandom % 7);
      logic [31:0] a = ((32'h20 + ($urandom % 12)) << RGN_OFS) | ($urandom & 32'hFF);
      run_op(code, a, 2'($urandom % 4), tag_for(code));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule